// File: doc/BRIEF.md
# Masked Vector Gather Sequencer

This block carries out one masked gather. It takes a vector of signed 64-bit indices, a base address, a scale and a displacement. It turns each active lane into one memory read over a request/response port, one request at a time and lowest lane first. Each returned 32-bit or 64-bit element is steered into its lane of a destination register held inside the block.

The mask acts as a record of progress. A lane's bit drops as soon as its data has landed. If a read comes back with a fault, the block stops at that lane. The finished lanes stay written with clear bits, and the unfinished lanes keep their bits. Feeding `dest_out` and `mask_out` back in as the operands of a new operation therefore resumes the gather where it stopped.

Illegal operand combinations are refused before any read is made. Each operation ends with a one-cycle done pulse that carries a status code.

Top module: `gather_seq`

## Requirements
- R1: The address of lane j is B + (index[j] << op_scale) + D, kept to the low ADDR_W bits with no overflow flag. B is op_base when op_base_en is 1 and zero otherwise. index[j] is op_index[64j+63:64j]. op_scale 0..3 means ×1, ×2, ×4, ×8. D is op_disp sign-extended from its low 8 bits (op_disp_sz=1), its low 16 bits (2) or all 32 bits (3), and D is zero for op_disp_sz=0.
- R2: One request is made per active lane, in ascending lane order. req_size is 1 for 64-bit elements (op_wide=1) and 0 for 32-bit elements.
- R3: A lane whose mask bit is 0 is not requested, and its destination field keeps its input value.
- R4: A returned element is written, from rsp_data bits, into dest_out[64j+63:64j] for op_wide=1, or into dest_out[32j+31:32j] from rsp_data[31:0] for op_wide=0. That lane's mask bit is then cleared. A completion with status OK leaves mask_out all zero.
- R5: With op_nomask=1 every lane below the lane count is loaded, and op_mask and op_mask_sel are ignored.
- R6: op_vlen 0, 1 and 2 select 2, 4 and 8 lanes. When an operation is accepted, mask bits at and above the lane count are cleared. Destination bits at and above lane count × element width are also zeroed at acceptance, and this holds even if the operation later faults.
- R7: A response with rsp_fault=1 ends the operation with status FAULT (1) and fault_lane set to that lane. Lanes completed before it stay written with their bits cleared. The faulting lane and later active lanes keep their bits, and no further request is made.
- R8: An operation is ILLEGAL (status 2) when op_dst_reg equals op_idx_reg, when op_nomask=0 and op_mask_sel=0, or when op_vlen=3. An ILLEGAL operation makes no request, and dest_out and mask_out take op_dest and op_mask unchanged.
- R9: If no lane is active after masking, done with status OK comes in the cycle after acceptance, with no request made.
- R10: At most one read is outstanding. A request holds req_valid, req_addr and req_size stable until req_ready is seen.
- R11: op_ready is 1 only while idle, and no request is made while idle. done is a one-cycle pulse, and status is OK=0, FAULT=1 or ILLEGAL=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Start an operation (taken when op_ready) |
| op_ready | output | 1 | Block is idle and can take an operation |
| op_wide | input | 1 | 1: 64-bit elements, 0: 32-bit elements |
| op_vlen | input | 2 | Lane count select: 0→2, 1→4, 2→8, 3 illegal |
| op_nomask | input | 1 | Load every lane regardless of mask |
| op_mask_sel | input | KSEL_W | Mask register number (0 is illegal when masked) |
| op_dst_reg | input | REG_W | Destination register number |
| op_idx_reg | input | REG_W | Index register number |
| op_base_en | input | 1 | Base address present |
| op_base | input | ADDR_W | Base address |
| op_index | input | LANES*ELEM_W | Signed 64-bit index per lane |
| op_scale | input | 2 | Log2 of index scale |
| op_disp | input | 32 | Displacement bits |
| op_disp_sz | input | 2 | Displacement size: none, 8, 16, 32 bits |
| op_mask | input | LANES | Incoming mask |
| op_dest | input | LANES*ELEM_W | Incoming destination contents |
| req_valid | output | 1 | Read request valid |
| req_ready | input | 1 | Read request accepted |
| req_addr | output | ADDR_W | Read address |
| req_size | output | 1 | 1: 8-byte read, 0: 4-byte read |
| rsp_valid | input | 1 | Read response valid |
| rsp_data | input | ELEM_W | Read data |
| rsp_fault | input | 1 | Read faulted |
| dest_out | output | LANES*ELEM_W | Destination register contents |
| mask_out | output | LANES | Mask register contents (pending lanes) |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | Completion status |
| fault_lane | output | $clog2(LANES) | Lane that faulted |

## Verification
Some properties are checked on every cycle. There is never a second request while a read is outstanding, and a stalled request holds still. Mask bits only fall during an operation, and bits above the lane count stay clear. An OK completion leaves an empty mask, a FAULT leaves the faulting lane pending, an ILLEGAL completion follows zero requests, and done lasts one cycle. Other behaviours only the bench's scenarios can show, because they need a model of the intended result: exact addresses under each scale, displacement size and base option, and truncation, plus lane order, lane steering for both element widths, upper-lane zeroing, and a fault followed by a resume from the returned mask.

// File: rtl/gather_pkg.sv
package gather_pkg;

   typedef enum logic [1:0] {
      GST_OK      = 2'd0,
      GST_FAULT   = 2'd1,
      GST_ILLEGAL = 2'd2
   } gst_e;

   typedef enum logic [1:0] {
      SQ_IDLE = 2'd0,
      SQ_REQ  = 2'd1,
      SQ_WAIT = 2'd2
   } sq_e;

   // Sign-extend the displacement according to its encoded size.
   function automatic logic [63:0] disp_ext(input logic [31:0] d, input logic [1:0] sz);
      case (sz)
         2'd0:    return 64'd0;
         2'd1:    return {{56{d[7]}}, d[7:0]};
         2'd2:    return {{48{d[15]}}, d[15:0]};
         default: return {{32{d[31]}}, d};
      endcase
   endfunction

endpackage

// File: rtl/gather_agen.sv
module gather_agen #(
   parameter int ADDR_W = 64,
   parameter int IDX_W  = 64
) (
   input  logic              base_en,
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  index,
   input  logic [1:0]        scale,
   input  logic [63:0]       disp,
   output logic [ADDR_W-1:0] addr
);
   logic [63:0] base_w;
   logic [63:0] scaled;
   logic [63:0] full;

   always_comb begin
      base_w = base_en ? 64'(base) : 64'd0;
      scaled = 64'(index) << scale;
      full   = base_w + scaled + disp;
      addr   = full[ADDR_W-1:0];
   end
endmodule

// File: rtl/gather_pick.sv
module gather_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         req,
   output logic                 any,
   output logic [$clog2(N)-1:0] idx
);
   localparam int W = $clog2(N);

   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = W'(i);
      end
      any = |req;
   end
endmodule

// File: rtl/gather_steer.sv
module gather_steer #(
   parameter int LANES  = 8,
   parameter int ELEM_W = 64
) (
   input  logic [LANES*ELEM_W-1:0]  cur,
   input  logic                     wr,
   input  logic                     wide,
   input  logic [$clog2(LANES)-1:0] lane,
   input  logic [ELEM_W-1:0]        data,
   output logic [LANES*ELEM_W-1:0]  nxt
);
   localparam int LANE_W = $clog2(LANES);
   localparam int HALF_W = ELEM_W / 2;
   localparam int SLICES = 2 * LANES;

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      localparam int HI = s % 2;
      logic hit_w;
      logic hit_n;
      assign hit_w = wr && wide && (lane == LANE_W'(s / 2));
      if (s < LANES) begin : g_narrow
         assign hit_n = wr && !wide && (lane == LANE_W'(s));
      end else begin : g_wide_only
         assign hit_n = 1'b0;
      end
      assign nxt[s*HALF_W +: HALF_W] = hit_w ? data[HI*HALF_W +: HALF_W] :
                                       hit_n ? data[HALF_W-1:0] :
                                               cur[s*HALF_W +: HALF_W];
   end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
   import gather_pkg::*;
#(
   parameter int LANES  = 8,
   parameter int ELEM_W = 64,
   parameter int ADDR_W = 64,
   parameter int REG_W  = 5,
   parameter int KSEL_W = 3
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       op_valid,
   output logic                       op_ready,
   input  logic                       op_wide,
   input  logic [1:0]                 op_vlen,
   input  logic                       op_nomask,
   input  logic [KSEL_W-1:0]          op_mask_sel,
   input  logic [REG_W-1:0]           op_dst_reg,
   input  logic [REG_W-1:0]           op_idx_reg,
   input  logic                       op_base_en,
   input  logic [ADDR_W-1:0]          op_base,
   input  logic [LANES*ELEM_W-1:0]    op_index,
   input  logic [1:0]                 op_scale,
   input  logic [31:0]                op_disp,
   input  logic [1:0]                 op_disp_sz,
   input  logic [LANES-1:0]           op_mask,
   input  logic [LANES*ELEM_W-1:0]    op_dest,
   output logic                       req_valid,
   input  logic                       req_ready,
   output logic [ADDR_W-1:0]          req_addr,
   output logic                       req_size,
   input  logic                       rsp_valid,
   input  logic [ELEM_W-1:0]          rsp_data,
   input  logic                       rsp_fault,
   output logic [LANES*ELEM_W-1:0]    dest_out,
   output logic [LANES-1:0]           mask_out,
   output logic                       done,
   output logic [1:0]                 status,
   output logic [$clog2(LANES)-1:0]   fault_lane
);
   localparam int LANE_W = $clog2(LANES);
   localparam int VEC_W  = LANES * ELEM_W;
   localparam int HALF_W = ELEM_W / 2;
   localparam int SLICES = 2 * LANES;

   // Elaboration-time parameter checks
   if (ELEM_W != 64) begin : g_bad_elem
      $error("gather_seq: ELEM_W must be 64 (index and wide element width)");
   end
   if (LANES < 2 || (1 << LANE_W) != LANES) begin : g_bad_lanes
      $error("gather_seq: LANES must be a power of two, at least 2");
   end
   if (ADDR_W < 16 || ADDR_W > 64) begin : g_bad_addr
      $error("gather_seq: ADDR_W must be within 16..64");
   end

   sq_e                st_q;
   gst_e               status_q;
   logic               done_q;
   logic [LANE_W-1:0]  flane_q;
   logic [LANE_W-1:0]  cur_q;
   logic               wide_q;
   logic               base_en_q;
   logic [ADDR_W-1:0]  base_q;
   logic [1:0]         scale_q;
   logic [63:0]        disp_q;
   logic [VEC_W-1:0]   idx_q;
   logic [VEC_W-1:0]   dest_q;
   logic [LANES-1:0]   mask_q;

   // Acceptance-time decode
   logic               illegal;
   logic [LANES-1:0]   lane_en;
   logic [LANES-1:0]   mask_init;
   logic [VEC_W-1:0]   dest_fill;
   logic [31:0]        lane_cnt;
   logic [31:0]        slice_cnt;

   always_comb begin
      lane_cnt  = 32'd2 << op_vlen;
      slice_cnt = op_wide ? (lane_cnt << 1) : lane_cnt;
      illegal   = (op_dst_reg == op_idx_reg) ||
                  (!op_nomask && (op_mask_sel == '0)) ||
                  (op_vlen == 2'd3) ||
                  (lane_cnt > 32'(LANES));
      for (int j = 0; j < LANES; j++) begin
         lane_en[j] = (32'(j) < lane_cnt);
      end
      mask_init = op_nomask ? lane_en : (op_mask & lane_en);
   end

   for (genvar s = 0; s < SLICES; s++) begin : g_fill
      assign dest_fill[s*HALF_W +: HALF_W] =
         (32'(s) < slice_cnt) ? op_dest[s*HALF_W +: HALF_W] : '0;
   end

   // Next lane and its address
   logic               pick_any;
   logic [LANE_W-1:0]  pick_idx;

   gather_pick #(.N(LANES)) u_pick (
      .req (mask_q),
      .any (pick_any),
      .idx (pick_idx)
   );

   gather_agen #(.ADDR_W(ADDR_W), .IDX_W(ELEM_W)) u_agen (
      .base_en (base_en_q),
      .base    (base_q),
      .index   (idx_q[pick_idx*ELEM_W +: ELEM_W]),
      .scale   (scale_q),
      .disp    (disp_q),
      .addr    (req_addr)
   );

   // Lane write-back
   logic               wr_lane;
   logic [VEC_W-1:0]   dest_wr;
   logic [LANES-1:0]   cur_oh;
   logic [LANES-1:0]   mask_left;

   assign wr_lane = (st_q == SQ_WAIT) && rsp_valid && !rsp_fault;

   gather_steer #(.LANES(LANES), .ELEM_W(ELEM_W)) u_steer (
      .cur  (dest_q),
      .wr   (wr_lane),
      .wide (wide_q),
      .lane (cur_q),
      .data (rsp_data),
      .nxt  (dest_wr)
   );

   always_comb begin
      cur_oh        = '0;
      cur_oh[cur_q] = 1'b1;
      mask_left     = mask_q & ~cur_oh;
   end

   // Sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= SQ_IDLE;
         status_q  <= GST_OK;
         done_q    <= 1'b0;
         flane_q   <= '0;
         cur_q     <= '0;
         wide_q    <= 1'b0;
         base_en_q <= 1'b0;
         base_q    <= '0;
         scale_q   <= '0;
         disp_q    <= '0;
         idx_q     <= '0;
         dest_q    <= '0;
         mask_q    <= '0;
      end else begin
         done_q <= 1'b0;
         case (st_q)
            SQ_IDLE: begin
               if (op_valid) begin
                  wide_q    <= op_wide;
                  base_en_q <= op_base_en;
                  base_q    <= op_base;
                  scale_q   <= op_scale;
                  disp_q    <= disp_ext(op_disp, op_disp_sz);
                  idx_q     <= op_index;
                  flane_q   <= '0;
                  if (illegal) begin
                     dest_q   <= op_dest;
                     mask_q   <= op_mask;
                     done_q   <= 1'b1;
                     status_q <= GST_ILLEGAL;
                  end else begin
                     dest_q <= dest_fill;
                     mask_q <= mask_init;
                     if (mask_init == '0) begin
                        done_q   <= 1'b1;
                        status_q <= GST_OK;
                     end else begin
                        st_q <= SQ_REQ;
                     end
                  end
               end
            end
            SQ_REQ: begin
               if (req_ready) begin
                  cur_q <= pick_idx;
                  st_q  <= SQ_WAIT;
               end
            end
            SQ_WAIT: begin
               if (rsp_valid) begin
                  if (rsp_fault) begin
                     st_q     <= SQ_IDLE;
                     done_q   <= 1'b1;
                     status_q <= GST_FAULT;
                     flane_q  <= cur_q;
                  end else begin
                     dest_q <= dest_wr;
                     mask_q <= mask_left;
                     if (mask_left == '0) begin
                        st_q     <= SQ_IDLE;
                        done_q   <= 1'b1;
                        status_q <= GST_OK;
                     end else begin
                        st_q <= SQ_REQ;
                     end
                  end
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign op_ready   = (st_q == SQ_IDLE);
   assign req_valid  = (st_q == SQ_REQ) && pick_any;
   assign req_size   = wide_q;
   assign dest_out   = dest_q;
   assign mask_out   = mask_q;
   assign done       = done_q;
   assign status     = status_q;
   assign fault_lane = flane_q;

endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
   parameter int LANES  = 8,
   parameter int ADDR_W = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     op_valid,
   input logic                     op_ready,
   input logic [1:0]               op_vlen,
   input logic                     req_valid,
   input logic                     req_ready,
   input logic [ADDR_W-1:0]        req_addr,
   input logic                     req_size,
   input logic                     rsp_valid,
   input logic [LANES-1:0]         mask_out,
   input logic                     done,
   input logic [1:0]               status,
   input logic [$clog2(LANES)-1:0] fault_lane
);
   logic             outstanding;
   logic [7:0]       req_cnt;
   logic [LANES-1:0] lane_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         outstanding <= 1'b0;
         req_cnt     <= '0;
         lane_en_q   <= '0;
      end else begin
         if (req_valid && req_ready) outstanding <= 1'b1;
         else if (rsp_valid)         outstanding <= 1'b0;
         if (op_valid && op_ready) begin
            req_cnt <= '0;
            for (int j = 0; j < LANES; j++) begin
               lane_en_q[j] <= (32'(j) < (32'd2 << op_vlen));
            end
         end else if (req_valid && req_ready) begin
            req_cnt <= req_cnt + 8'd1;
         end
      end
   end

   AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding |-> !req_valid);                                          // R10
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_size))); // R10
   AST_MASK_ONLY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      !op_ready |=> ((mask_out & ~$past(mask_out)) == '0));                 // R4
   AST_OK_MASK_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd0) |-> (mask_out == '0));                       // R4
   AST_UPPER_MASK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !op_ready |-> ((mask_out & ~lane_en_q) == '0));                       // R6
   AST_FAULT_LANE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> mask_out[fault_lane]);                   // R7
   AST_ILLEGAL_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd2) |-> (req_cnt == 8'd0));                      // R8
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);                                                      // R11
   AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      op_ready |-> !req_valid);                                             // R11

endmodule

bind gather_seq gather_seq_chk #(.LANES(LANES), .ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .op_valid   (op_valid),
   .op_ready   (op_ready),
   .op_vlen    (op_vlen),
   .req_valid  (req_valid),
   .req_ready  (req_ready),
   .req_addr   (req_addr),
   .req_size   (req_size),
   .rsp_valid  (rsp_valid),
   .mask_out   (mask_out),
   .done       (done),
   .status     (status),
   .fault_lane (fault_lane)
);

// File: tb/gather_seq_bench.sv
module gather_seq_bench;
   localparam int AW = 40;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         op_valid = 1'b0;
   logic         op_ready;
   logic         t_wide = 1'b0;
   logic [1:0]   t_vlen = 2'd0;
   logic         t_nomask = 1'b0;
   logic [2:0]   t_msel = 3'd1;
   logic [4:0]   t_dst = 5'd1;
   logic [4:0]   t_idx = 5'd2;
   logic         t_base_en = 1'b0;
   logic [AW-1:0] t_base = '0;
   logic [511:0] t_index = '0;
   logic [1:0]   t_scale = 2'd0;
   logic [31:0]  t_disp = '0;
   logic [1:0]   t_dsz = 2'd0;
   logic [7:0]   t_mask = '0;
   logic [511:0] t_dest = '0;
   logic         req_valid;
   logic         req_ready = 1'b0;
   logic [AW-1:0] req_addr;
   logic         req_size;
   logic         rsp_valid = 1'b0;
   logic [63:0]  rsp_data = '0;
   logic         rsp_fault = 1'b0;
   logic [511:0] dest_out;
   logic [7:0]   mask_out;
   logic         done;
   logic [1:0]   status;
   logic [2:0]   fault_lane;

   logic          fault_en = 1'b0;
   logic [AW-1:0] fault_addr = '0;
   int            n_chk = 0;
   int            n_bad = 0;
   int            stall_tog = 0;

   always #10 clk = ~clk;

   gather_seq #(.ADDR_W(AW)) u_gather_seq (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_ready(op_ready),
      .op_wide(t_wide), .op_vlen(t_vlen), .op_nomask(t_nomask),
      .op_mask_sel(t_msel), .op_dst_reg(t_dst), .op_idx_reg(t_idx),
      .op_base_en(t_base_en), .op_base(t_base), .op_index(t_index),
      .op_scale(t_scale), .op_disp(t_disp), .op_disp_sz(t_dsz),
      .op_mask(t_mask), .op_dest(t_dest),
      .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
      .req_size(req_size), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .rsp_fault(rsp_fault), .dest_out(dest_out), .mask_out(mask_out),
      .done(done), .status(status), .fault_lane(fault_lane)
   );

   task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Expected address of lane j from R1, using the current operands.
   function automatic logic [AW-1:0] ea(input int j);
      logic [63:0] d;
      logic [63:0] s;
      case (t_dsz)
         2'd0: d = 64'd0;
         2'd1: d = {{56{t_disp[7]}}, t_disp[7:0]};
         2'd2: d = {{48{t_disp[15]}}, t_disp[15:0]};
         default: d = {{32{t_disp[31]}}, t_disp};
      endcase
      s = (t_base_en ? 64'(t_base) : 64'd0) + (t_index[64*j +: 64] << t_scale) + d;
      return s[AW-1:0];
   endfunction

   function automatic logic [63:0] mdata(input logic [AW-1:0] a);
      return {a[31:0] ^ 32'h5A5A_0F0F, a[31:0] + 32'h0001_1111};
   endfunction

   task automatic run_op(input string tag);
      int            lanes;
      int            ew;
      int            cyc;
      bit            ill;
      bit            got;
      logic [7:0]    lm;
      logic [511:0]  e_dest;
      logic [7:0]    e_mask;
      logic [1:0]    e_stat;
      logic [2:0]    e_fl;
      logic [AW-1:0] q[$];
      logic [AW-1:0] a;
      logic [AW-1:0] ex;
      logic [63:0]   d;
      lanes = 2 << t_vlen;
      ew    = t_wide ? 64 : 32;
      ill   = (t_dst == t_idx) || (!t_nomask && t_msel == 3'd0) || (t_vlen == 2'd3);
      lm    = '0;
      e_fl  = '0;
      for (int j = 0; j < 8; j++) if (j < lanes) lm[j] = 1'b1;
      if (ill) begin
         e_dest = t_dest; e_mask = t_mask; e_stat = 2'd2;
      end else begin
         e_dest = t_dest;
         for (int b = 0; b < 512; b++) if (b >= lanes * ew) e_dest[b] = 1'b0;
         e_mask = t_nomask ? lm : (t_mask & lm);
         e_stat = 2'd0;
         for (int j = 0; j < lanes; j++) begin
            if (e_mask[j]) begin
               a = ea(j);
               q.push_back(a);
               if (fault_en && a == fault_addr) begin
                  e_stat = 2'd1; e_fl = 3'(j);
                  break;
               end
               d = mdata(a);
               if (t_wide) e_dest[64*j +: 64] = d;
               else        e_dest[32*j +: 32] = d[31:0];
               e_mask[j] = 1'b0;
            end
         end
      end
      @(negedge clk);
      op_valid = 1'b1;
      @(negedge clk);
      op_valid = 1'b0;
      got = 0;
      cyc = 0;
      while (!got && cyc < 500) begin
         if (done) begin
            got = 1;
         end else if (req_valid) begin
            if (q.size() == 0) begin
               chk({tag, " R2 unexpected request"}, 512'(req_addr), '0);
               ex = req_addr;
            end else begin
               ex = q.pop_front();
               chk({tag, " R1 address"}, 512'(req_addr), 512'(ex));
               chk({tag, " R2 size"}, 512'(req_size), 512'(t_wide));
            end
            stall_tog++;
            if (stall_tog % 3 == 0) begin
               @(negedge clk);
               chk({tag, " R10 held request"}, 512'({req_valid, req_addr}), 512'({1'b1, ex}));
            end
            req_ready = 1'b1;
            @(negedge clk);
            req_ready = 1'b0;
            chk({tag, " R10 single outstanding"}, 512'(req_valid), '0);
            if (stall_tog % 2 == 0) @(negedge clk);
            rsp_valid = 1'b1;
            rsp_data  = mdata(ex);
            rsp_fault = fault_en && (ex == fault_addr);
            @(negedge clk);
            rsp_valid = 1'b0;
            rsp_fault = 1'b0;
         end else begin
            chk({tag, " R11 busy"}, 512'(op_ready), '0);
            @(negedge clk);
         end
         cyc++;
      end
      chk({tag, " R11 done seen"}, 512'(got), 512'(1));
      chk({tag, " R11 status"}, 512'(status), 512'(e_stat));
      if (e_stat == 2'd1) chk({tag, " R7 fault lane"}, 512'(fault_lane), 512'(e_fl));
      chk({tag, " dest"}, dest_out, e_dest);
      chk({tag, " mask"}, 512'(mask_out), 512'(e_mask));
      chk({tag, " R2 request count"}, 512'(q.size()), '0);
      @(negedge clk);
      chk({tag, " R11 done pulse"}, 512'(done), '0);
      chk({tag, " R11 ready"}, 512'(op_ready), 512'(1));
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R11 reset ready", 512'({op_ready, done, req_valid}), 512'(3'b100));
      chk("R11 reset mask", 512'(mask_out), '0);
      rst_n = 1'b1;

      // T1 R4: wide, eight lanes, scale 8, negative 32-bit displacement
      t_wide = 1; t_vlen = 2; t_mask = 8'hFF; t_base_en = 1; t_base = 40'h12_3400_0000;
      t_scale = 3; t_disp = 32'hFFFF_FF00; t_dsz = 3;
      for (int j = 0; j < 8; j++) t_index[64*j +: 64] = 64'(j * 37) - 64'd100;
      t_dest = {16{32'hDEAD_BEEF}};
      run_op("R4 wide8");

      // T2 R3 R6: narrow, four lanes, sparse mask, upper lanes zeroed
      t_wide = 0; t_vlen = 1; t_mask = 8'b1111_1010; t_scale = 2; t_dsz = 2; t_disp = 32'h0000_8010;
      t_dest = {16{32'hFFFF_FFFF}};
      run_op("R3 R6 narrow4");

      // T3 R5: no-mask mode, two lanes, mask select 0 ignored
      t_nomask = 1; t_msel = 0; t_vlen = 0; t_mask = 8'h00; t_scale = 1; t_dsz = 1; t_disp = 32'h0000_0081;
      run_op("R5 nomask2");
      t_nomask = 0; t_msel = 3;

      // T4 R1: absent base, index wraps past the address width
      t_base_en = 0; t_wide = 1; t_vlen = 1; t_mask = 8'h0F; t_scale = 3; t_dsz = 0;
      t_index[0 +: 64]   = 64'h7FFF_FFFF_FFFF_FFF0;
      t_index[64 +: 64]  = 64'hFFFF_FFFF_FFFF_FFFF;
      t_index[128 +: 64] = 64'h0000_0123_4567_89AB;
      t_index[192 +: 64] = 64'h8000_0000_0000_0000;
      run_op("R1 truncate");

      // T5 R7: fault on lane 2 of an eight-lane narrow gather, then resume
      t_base_en = 1; t_wide = 0; t_vlen = 2; t_mask = 8'b1011_0111; t_scale = 2; t_dsz = 3; t_disp = 32'h40;
      for (int j = 0; j < 8; j++) t_index[64*j +: 64] = 64'(j * 5);
      t_dest = {16{32'hA0A0_A0A0}};
      fault_en = 1; fault_addr = ea(2);
      run_op("R7 fault");
      fault_en = 0; t_mask = mask_out; t_dest = dest_out;
      run_op("R7 resume");

      // T6 R7: fault on the very first active lane, wide four lanes
      t_wide = 1; t_vlen = 1; t_mask = 8'b0000_1100; t_dest = {8{64'h1111_2222_3333_4444}};
      fault_en = 1; fault_addr = ea(2);
      run_op("R7 first fault");
      fault_en = 0;

      // T7 R8: destination equals index register
      t_dst = 5'd7; t_idx = 5'd7; t_mask = 8'hF3; t_dest = {16{32'h5555_AAAA}};
      run_op("R8 same reg");
      t_idx = 5'd9;

      // T8 R8: mask register 0 while masked
      t_msel = 0; run_op("R8 mask zero");
      t_msel = 2;

      // T9 R8: reserved lane count
      t_vlen = 3; run_op("R8 vlen3");

      // T10 R9 R6: only bits above the lane count set, so nothing active
      t_vlen = 1; t_wide = 0; t_mask = 8'hF0; t_dest = {16{32'h7777_7777}};
      run_op("R9 R6 empty");

      // T11 R9: empty mask at full length
      t_vlen = 2; t_wide = 1; t_mask = 8'h00;
      run_op("R9 empty8");

      // T12 R2: single top lane, narrow eight lanes
      t_wide = 0; t_mask = 8'h80; t_scale = 0; t_dsz = 1; t_disp = 32'h7F;
      run_op("R2 top lane");

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule